// File: doc/BRIEF.md
# Dual-Clock FIFO with Encoded Fill Flags

A first-in first-out buffer for 18-bit words with 512 locations. Writes are taken on the rising edge of a write clock and reads on the rising edge of a separate read clock. Each port has an active-low enable. Three active-low status outputs together encode one of six fill states. Two of those states are "almost" windows whose width P comes from a program register.

The program register can be written or read back only while master reset is held low. A retransmit strobe rewinds the read side to location 0 so that stored data can be replayed. A flag belongs to the clock domain that can move the FIFO toward it, and only that domain updates it. The empty, almost-empty and empty-side code bits change on read-clock edges. The half-full, almost-full and full bits change on write-clock edges. Both domains update their flags on every edge, whatever their enable.

At each edge, a domain uses the other domain's pointer as it stands at that edge. When the opposite side has just moved the FIFO off empty or off full, the next edge of the blocked side only clears the flag. That edge is a latent cycle and moves no data.

Top module: `dcfifo_flags`

## Requirements
- R1: When `wr_en_n` is low and the full code is not shown, a `wr_clk` edge stores `din`. When `rd_en_n` is low and the empty code is not shown, a `rd_clk` edge loads the oldest stored word into the output register. Words come out in the order they were written.
- R2: `{empty_full_n, almost_n, half_n}` reads 3'b001 at 0 words, 3'b101 at 1..P words and 3'b111 at P+1..256 words. It reads 3'b110 at 257..511−P words, 3'b100 at 512−P..511 words and 3'b000 at 512 words.
- R3: The empty and almost-empty terms are recomputed on every `rd_clk` edge and on no other edge. The full, almost-full and half-full terms are recomputed on every `wr_clk` edge and on no other edge. In both cases this happens whether or not the enable is active.
- R4: Suppose the empty code is shown and a word has been written. The next `rd_clk` edge clears the empty code but does not read, even with `rd_en_n` low. The following enabled edge delivers the word.
- R5: Suppose the full code is shown and a word has been read. The next `wr_clk` edge clears the full code but does not store, even with `wr_en_n` low.
- R6: A write attempted while the full code is shown is discarded and never appears at `dout`. A read attempted while the empty code is shown leaves `dout` holding the last word read.
- R7: On a clock edge with `mrst_n` low, both pointers are cleared and the flags show 3'b001. On the first `rd_clk` edge after `mrst_n` returns high, `dout` becomes all zeros.
- R8: While `mrst_n` is low, a `wr_clk` edge with `wr_en_n` low loads P from `din[7:0]` and a 3-bit mode field from `din[17:15]`. A `rd_clk` edge with `rd_en_n` low places the register on `dout`, with P in bits 7:0, the mode in bits 17:15 and zeros elsewhere.
- R9: A reset period with no program write sets P to 16 and the mode to 0. With P = 0, the almost code appears only together with empty or full.
- R10: A `rd_clk` edge with `rt_n` low sets the read position to location 0 and performs no read. Later reads replay the stored words from the first one, and the flags follow the new pointer offset.
- R11: With `oe_n` high, `dout` is all zeros and `dout_vld` is low. With `oe_n` low, `dout` shows the output register and `dout_vld` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write clock |
| rd_clk | input | 1 | Read clock |
| mrst_n | input | 1 | Master reset, active low; program access window |
| wr_en_n | input | 1 | Write enable, active low |
| rd_en_n | input | 1 | Read enable, active low |
| rt_n | input | 1 | Retransmit strobe, active low, sampled on rd_clk |
| oe_n | input | 1 | Output enable, active low |
| din | input | 18 | Write data / program word |
| dout | output | 18 | Read data / program read-back |
| dout_vld | output | 1 | High when dout carries the output register |
| empty_full_n | output | 1 | Low at empty or full |
| almost_n | output | 1 | Low within P of empty or of full |
| half_n | output | 1 | Low above half full |

## Verification
The bench uses the default 18-bit width and 512-word depth, which gives an 8-bit P field. At this size, filling to full and draining back to empty takes about a thousand cycles, so every one of the six codes is reached by real traffic. The two clocks are tied together, so each latent cycle and each same-edge write and read happens in a fixed, predictable cycle. The program values P = 4, P = 0 and the default 16 all land in reach, which exercises both edges of each almost window.

// File: rtl/dcf_pkg.sv
`timescale 1ns/1ps
package dcf_pkg;
   localparam int unsigned MODE_W = 3;
   typedef logic [MODE_W-1:0] pmode_t;
   localparam pmode_t MODE_OFF = '0;
endpackage

// File: rtl/dcf_ram.sv
`timescale 1ns/1ps
module dcf_ram #(
   parameter int unsigned W     = 18,
   parameter int unsigned DEPTH = 512
) (
   input  logic                     wclk,
   input  logic                     we,
   input  logic [$clog2(DEPTH)-1:0] waddr,
   input  logic [W-1:0]             wdata,
   input  logic [$clog2(DEPTH)-1:0] raddr,
   output logic [W-1:0]             rdata
);
   logic [W-1:0] cells [DEPTH];

   always_ff @(posedge wclk) begin
      if (we) cells[waddr] <= wdata;
   end

   assign rdata = cells[raddr];
endmodule

// File: rtl/dcf_wside.sv
`timescale 1ns/1ps
module dcf_wside import dcf_pkg::*; #(
   parameter int unsigned DEPTH = 512,
   parameter int unsigned PW    = 8,
   parameter int unsigned DEF_P = 16
) (
   input  logic                     wclk,
   input  logic                     mrst_n,
   input  logic                     wen_n,
   input  logic [PW-1:0]            p_in,
   input  pmode_t                   mode_in,
   input  logic [$clog2(DEPTH):0]   rptr,
   output logic                     we,
   output logic [$clog2(DEPTH)-1:0] waddr,
   output logic [$clog2(DEPTH):0]   wptr,
   output logic [PW-1:0]            prog_p,
   output pmode_t                   prog_mode,
   output logic                     full_q,
   output logic                     hf_q,
   output logic                     af_q
);
   localparam int unsigned AW   = $clog2(DEPTH);
   localparam int unsigned PTRW = AW + 1;
   localparam logic [PTRW-1:0] FULL_LVL = PTRW'(DEPTH);
   localparam logic [PTRW-1:0] HALF_LVL = PTRW'(DEPTH / 2);

   logic [PTRW-1:0] wptr_q, wptr_d, lvl, af_lvl;
   logic            accept, wrst_q;

   // rptr is taken as this edge's snapshot of the read side
   always_comb begin
      accept = mrst_n && !wen_n && !full_q;
      wptr_d = wptr_q + PTRW'(accept);
      lvl    = wptr_d - rptr;
      af_lvl = FULL_LVL - PTRW'(prog_p);
   end

   assign we    = accept;
   assign waddr = wptr_q[AW-1:0];
   assign wptr  = wptr_q;

   always_ff @(posedge wclk) begin
      wrst_q <= mrst_n;
      if (!mrst_n) begin
         wptr_q <= '0;
         full_q <= 1'b0;
         hf_q   <= 1'b0;
         af_q   <= 1'b0;
         if (!wen_n) begin
            prog_p    <= p_in;
            prog_mode <= mode_in;
         end else if (wrst_q) begin
            prog_p    <= PW'(DEF_P);
            prog_mode <= MODE_OFF;
         end
      end else begin
         wptr_q <= wptr_d;
         full_q <= (lvl >= FULL_LVL);
         hf_q   <= (lvl > HALF_LVL);
         af_q   <= (lvl >= af_lvl);
      end
   end

   AST_NO_WRITE_WHEN_FULL: assert property (@(posedge wclk) disable iff (!mrst_n)
      full_q |=> $stable(wptr_q)); // R6
   AST_FULL_IMPLIES_UPPER: assert property (@(posedge wclk) disable iff (!mrst_n)
      full_q |-> (hf_q && af_q)); // R2
   AST_PROG_HOLD: assert property (@(posedge wclk) disable iff (!mrst_n)
      mrst_n |=> $stable({prog_mode, prog_p})); // R8
endmodule

// File: rtl/dcf_rside.sv
`timescale 1ns/1ps
module dcf_rside #(
   parameter int unsigned W     = 18,
   parameter int unsigned DEPTH = 512,
   parameter int unsigned PW    = 8
) (
   input  logic                     rclk,
   input  logic                     mrst_n,
   input  logic                     ren_n,
   input  logic                     rt_n,
   input  logic [$clog2(DEPTH):0]   wptr,
   input  logic [W-1:0]             rdata,
   input  logic [W-1:0]             prog_word,
   input  logic [PW-1:0]            prog_p,
   output logic [$clog2(DEPTH)-1:0] raddr,
   output logic [$clog2(DEPTH):0]   rptr,
   output logic [W-1:0]             dout_q,
   output logic                     empty_q,
   output logic                     ae_q
);
   localparam int unsigned AW   = $clog2(DEPTH);
   localparam int unsigned PTRW = AW + 1;

   logic [PTRW-1:0] rptr_q, rptr_d, lvl;
   logic            accept, rrst_q;

   // wptr is taken as this edge's snapshot of the write side
   always_comb begin
      accept = mrst_n && rt_n && !ren_n && !empty_q;
      rptr_d = !rt_n ? '0 : rptr_q + PTRW'(accept);
      lvl    = wptr - rptr_d;
   end

   assign raddr = rptr_q[AW-1:0];
   assign rptr  = rptr_q;

   always_ff @(posedge rclk) begin
      rrst_q <= mrst_n;
      if (!mrst_n) begin
         rptr_q  <= '0;
         empty_q <= 1'b1;
         ae_q    <= 1'b1;
         if (!ren_n) dout_q <= prog_word;
      end else begin
         rptr_q  <= rptr_d;
         empty_q <= (lvl == '0);
         ae_q    <= (lvl <= PTRW'(prog_p));
         if (!rrst_q)     dout_q <= '0;
         else if (accept) dout_q <= rdata;
      end
   end

   AST_NO_READ_WHEN_EMPTY: assert property (@(posedge rclk) disable iff (!mrst_n)
      (empty_q && rt_n) |=> $stable(rptr_q)); // R6
   AST_DOUT_HOLD_EMPTY: assert property (@(posedge rclk) disable iff (!mrst_n)
      (empty_q && rrst_q) |=> $stable(dout_q)); // R6
   AST_RT_REWIND: assert property (@(posedge rclk) disable iff (!mrst_n)
      !rt_n |=> (rptr_q == '0)); // R10
   AST_EMPTY_IMPLIES_AE: assert property (@(posedge rclk) disable iff (!mrst_n)
      empty_q |-> ae_q); // R2
endmodule

// File: rtl/dcfifo_flags.sv
`timescale 1ns/1ps
module dcfifo_flags import dcf_pkg::*; #(
   parameter int unsigned W     = 18,
   parameter int unsigned DEPTH = 512,
   parameter int unsigned DEF_P = 16
) (
   input  logic         wr_clk,
   input  logic         rd_clk,
   input  logic         mrst_n,
   input  logic         wr_en_n,
   input  logic         rd_en_n,
   input  logic         rt_n,
   input  logic         oe_n,
   input  logic [W-1:0] din,
   output logic [W-1:0] dout,
   output logic         dout_vld,
   output logic         empty_full_n,
   output logic         almost_n,
   output logic         half_n
);
   localparam int unsigned AW   = $clog2(DEPTH);
   localparam int unsigned PTRW = AW + 1;
   localparam int unsigned PW   = AW - 1;

   if ((1 << AW) != DEPTH || DEPTH < 8) begin : g_bad_depth
      $error("DEPTH must be a power of two of at least 8");
   end
   if (W < PW + MODE_W) begin : g_bad_width
      $error("W too narrow for the program word");
   end
   if (DEF_P >= (1 << PW)) begin : g_bad_defp
      $error("DEF_P does not fit the P field");
   end

   logic [PTRW-1:0] wptr, rptr;
   logic [AW-1:0]   waddr, raddr;
   logic [W-1:0]    rdata, dout_q, prog_word;
   logic [PW-1:0]   prog_p;
   pmode_t          prog_mode;
   logic            we, full_q, hf_q, af_q, empty_q, ae_q;

   dcf_ram #(.W(W), .DEPTH(DEPTH)) u_ram (
      .wclk(wr_clk), .we(we), .waddr(waddr), .wdata(din),
      .raddr(raddr), .rdata(rdata));

   dcf_wside #(.DEPTH(DEPTH), .PW(PW), .DEF_P(DEF_P)) u_wside (
      .wclk(wr_clk), .mrst_n(mrst_n), .wen_n(wr_en_n),
      .p_in(din[PW-1:0]), .mode_in(din[W-1 -: MODE_W]), .rptr(rptr),
      .we(we), .waddr(waddr), .wptr(wptr), .prog_p(prog_p),
      .prog_mode(prog_mode), .full_q(full_q), .hf_q(hf_q), .af_q(af_q));

   dcf_rside #(.W(W), .DEPTH(DEPTH), .PW(PW)) u_rside (
      .rclk(rd_clk), .mrst_n(mrst_n), .ren_n(rd_en_n), .rt_n(rt_n),
      .wptr(wptr), .rdata(rdata), .prog_word(prog_word), .prog_p(prog_p),
      .raddr(raddr), .rptr(rptr), .dout_q(dout_q),
      .empty_q(empty_q), .ae_q(ae_q));

   always_comb begin
      prog_word                = '0;
      prog_word[PW-1:0]        = prog_p;
      prog_word[W-1 -: MODE_W] = prog_mode;
   end

   assign empty_full_n = ~(empty_q | full_q);
   assign almost_n     = ~(ae_q | af_q);
   assign half_n       = ~hf_q;
   assign dout         = oe_n ? '0 : dout_q;
   assign dout_vld     = ~oe_n;
endmodule

// File: tb/sim_dcfifo_flags.sv
`timescale 1ns/1ps
module sim_dcfifo_flags;
   localparam int D = 512;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic        mrst_n, wr_en_n, rd_en_n, rt_n, oe_n;
   logic [17:0] din, dout;
   logic        dout_vld, empty_full_n, almost_n, half_n;

   dcfifo_flags u0 (
      .wr_clk(clk), .rd_clk(clk), .mrst_n(mrst_n), .wr_en_n(wr_en_n),
      .rd_en_n(rd_en_n), .rt_n(rt_n), .oe_n(oe_n), .din(din), .dout(dout),
      .dout_vld(dout_vld), .empty_full_n(empty_full_n), .almost_n(almost_n),
      .half_n(half_n));

   int    total = 0, bad = 0;
   bit    armed = 0, done = 0;
   string req = "R7";

   // behavioural reference state
   int          wp = 0, rp = 0, pval = 16;
   logic [2:0]  md = 3'd0;
   logic [17:0] store [D];
   logic [17:0] dq = '0;
   bit fullf = 0, hff = 0, aff = 0, emf = 1, aef = 1, wprev = 0, rprev = 0;

   function automatic logic [17:0] pword(int p, logic [2:0] m);
      logic [17:0] v = '0;
      v[7:0]   = p[7:0];
      v[17:15] = m;
      return v;
   endfunction

   always @(posedge clk) begin : model
      int nwp, nrp, lvw, lvr;
      bit racc, wacc;
      logic [17:0] ndq;
      nwp = wp; nrp = rp; ndq = dq;
      if (!mrst_n) begin
         if (!rd_en_n) ndq = pword(pval, md);
         nwp = 0; nrp = 0;
         fullf = 0; hff = 0; aff = 0; emf = 1; aef = 1;
         if (!wr_en_n) begin pval = int'(din[7:0]); md = din[17:15]; end
         else if (wprev) begin pval = 16; md = 3'd0; end
      end else begin
         racc = !rd_en_n && !emf && rt_n;
         nrp  = !rt_n ? 0 : rp + int'(racc);
         if (!rprev) ndq = '0;
         else if (racc) ndq = store[rp % D];
         wacc = !wr_en_n && !fullf;
         if (wacc) store[wp % D] = din;
         nwp = wp + int'(wacc);
         lvw = nwp - rp;
         lvr = wp - nrp;
         fullf = (lvw >= D); hff = (lvw > D/2); aff = (lvw >= D - pval);
         emf = (lvr == 0);   aef = (lvr <= pval);
      end
      wp = nwp; rp = nrp; dq = ndq;
      wprev = mrst_n; rprev = mrst_n;
   end

   task automatic chk(input string what, input logic [17:0] act, input logic [17:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic step();
      @(negedge clk);
      if (armed) begin
         chk("dout", dout, oe_n ? 18'h0 : dq);
         chk("dout_vld", 18'(dout_vld), 18'(!oe_n));
         chk("flags", 18'({empty_full_n, almost_n, half_n}),
             18'({!(emf | fullf), !(aef | aff), !hff}));
      end
   endtask

   task automatic steps(input int n);
      for (int i = 0; i < n; i++) step();
   endtask

   initial begin
      mrst_n = 1; wr_en_n = 1; rd_en_n = 1; rt_n = 1; oe_n = 0; din = '0;
      steps(2);
      // R7: reset state
      req = "R7"; mrst_n = 0; step(); armed = 1; step();
      chk("reset code", 18'({empty_full_n, almost_n, half_n}), 18'b001);
      // R9: default program word read in reset
      req = "R9"; rd_en_n = 0; step();
      chk("default P", dout, 18'd16);
      // R8: program P=4, mode 101, then read it back
      req = "R8"; rd_en_n = 1; wr_en_n = 0; din = 18'h28004; step();
      wr_en_n = 1; rd_en_n = 0; step();
      chk("prog readback", dout, 18'h28004);
      rd_en_n = 1; mrst_n = 1; step();
      req = "R7"; chk("dout zero after release", dout, 18'h0);
      // R3: read-side flags move with read enable off
      req = "R3"; wr_en_n = 0;
      for (int i = 1; i <= 3; i++) begin din = 18'(i); step(); end
      wr_en_n = 1; steps(2);
      chk("code at 3 words P=4", 18'({empty_full_n, almost_n, half_n}), 18'b101);
      // R1: ordered reads
      req = "R1"; rd_en_n = 0; steps(4); rd_en_n = 1; step();
      chk("last word", dout, 18'd3);
      // R4: latent cycle leaving empty
      req = "R4"; wr_en_n = 0; rd_en_n = 0; din = 18'h155; step();
      wr_en_n = 1; step();
      chk("latent edge keeps dout", dout, 18'd3);
      step();
      chk("word after latent", dout, 18'h155);
      rd_en_n = 1; step();
      // R2: fill through every code
      req = "R2"; wr_en_n = 0;
      for (int i = 0; i < D; i++) begin din = 18'(i * 7 + 1); step(); end
      chk("full code", 18'({empty_full_n, almost_n, half_n}), 18'b000);
      // R6: writes while full are dropped
      req = "R6";
      for (int i = 0; i < 3; i++) begin din = 18'h3FFFF; step(); end
      // R5: latent cycle leaving full
      req = "R5"; rd_en_n = 0; din = 18'h0AAAA; step();
      rd_en_n = 1; step();
      chk("full cleared", 18'(empty_full_n), 18'd1);
      step(); wr_en_n = 1; step();
      // R6: drain past empty, output holds
      req = "R6"; rd_en_n = 0; steps(D + 8);
      chk("hold last word", dout, 18'h0AAAA);
      rd_en_n = 1; step();
      // R11: output enable
      req = "R11"; oe_n = 1; step();
      chk("dout off", dout, 18'h0);
      oe_n = 0; step();
      // R10: retransmit
      req = "R10"; mrst_n = 0; steps(2); mrst_n = 1; step();
      wr_en_n = 0;
      for (int i = 0; i < 5; i++) begin din = 18'(18'h100 + i); step(); end
      wr_en_n = 1; step(); rd_en_n = 0; steps(3); rd_en_n = 1;
      rt_n = 0; step(); rt_n = 1; step();
      rd_en_n = 0; step();
      chk("replay first", dout, 18'h100);
      steps(6); rd_en_n = 1;
      chk("replay last", dout, 18'h104);
      // R9: P = 0, then reset without program write restores 16
      req = "R9"; mrst_n = 0; wr_en_n = 0; din = 18'h0; step();
      wr_en_n = 1; step(); mrst_n = 1; step();
      wr_en_n = 0; din = 18'h77; step(); wr_en_n = 1; steps(2);
      chk("P=0 one word", 18'({empty_full_n, almost_n, half_n}), 18'b111);
      mrst_n = 0; rd_en_n = 0; steps(2);
      chk("default restored", dout, 18'd16);
      rd_en_n = 1; mrst_n = 1; steps(2);
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #500000;
      if (!done) begin
         bad++; total++;
         $display("FAIL watchdog %s: actual=timeout expected=finish", req);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule